// File: doc/BRIEF.md
# Receive Word Queue with Two-Step Host Readout

This block sits behind a serial line receiver and its label filter. Each accepted 32-bit avionics word arrives on a one-cycle valid strobe and is queued in first-in, first-out order. The queue holds up to 32 words. A host with a 16-bit data bus collects each word in two read steps. A half-select input picks which 16-bit half is driven while the read enable is high. The queue advances only after the upper half has been read, so the host can re-read the lower half as often as it needs to.

Three status outputs report the queue level: a word-available flag, a half-level flag and a no-room flag. A mode input picks how the word bits reach the bus. In raw mode the word is split straight down the middle. In reordered mode the halves are rearranged around the protocol fields. The label is bit-reversed and grouped with the source/destination code and the low data bits. The upper half carries the high data bits, then the sign/status pair, then the parity bit.

Top module: `rx_split_fifo`

## Requirements
- R1: After reset the queue is empty: `data_ready`, `half_full` and `full` are 0, and `rd_data` is 0.
- R2: Words are returned in the order in which they were accepted.
- R3: A word offered while the queue holds 32 words is dropped. The 32 stored words and their order stay unchanged, and `full` stays 1.
- R4: While `rd_en` is 0, `rd_data` is 0.
- R5: While `rd_en` is 1, `rd_half`=0 drives the lower half and `rd_half`=1 drives the upper half. A lower-half read leaves the queue unchanged.
- R6: A clock edge with `rd_en`=1 and `rd_half`=1 removes the oldest word, provided the queue is not empty.
- R7: `data_ready` is 1 exactly when the queue holds one or more words.
- R8: `half_full` is 1 exactly when the queue holds 16 or more words.
- R9: `full` is 1 exactly when the queue holds 32 words.
- R10: With `unscramble`=0, the lower half is word[15:0] and the upper half is word[31:16].
- R11: With `unscramble`=1, the lower half is {word[15:10], word[9:8], word[0..7]}, where the label field word[7:0] appears bit-reversed in bits 7:0. The upper half is {word[28:16], word[30:29], word[31]}, with the parity bit word[31] in bit 0.
- R12: A read of an empty queue drives `rd_data` to 0 and leaves the queue empty.
- R13: When a word arrives and an upper-half read happens on the same edge with a non-full, non-empty queue, the level stays the same. The new word is queued behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Accepted word strobe from the label filter |
| wr_word | input | 32 | Accepted word, label in bits 7:0 |
| rd_en | input | 1 | Host read enable |
| rd_half | input | 1 | Half select: 0 lower, 1 upper (pops) |
| unscramble | input | 1 | Bit mapping: 0 raw, 1 reordered |
| rd_data | output | 16 | Host read data |
| data_ready | output | 1 | Queue not empty |
| half_full | output | 1 | Queue holds at least 16 words |
| full | output | 1 | Queue holds 32 words |

## Verification
The bench fills the queue to exactly 32 words and offers one more. A design that overwrote the oldest slot or advanced a pointer would return a stray word during the drain, or lose the first one. The thresholds are probed one word on each side of 16 and 32, which exposes off-by-one comparisons. Repeated lower-half reads and an upper-half read of an empty queue catch a pop on the wrong step and a pointer that slips on underflow. A fixed word with distinct field values checks that the reordered mapping really reverses the label and puts parity at bit 0. A swapped slice would show up as a wrong half.

// File: rtl/arx_rx_pkg.sv
package arx_rx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int LABEL_W = 8;

    typedef enum logic {
        MAP_RAW   = 1'b0,
        MAP_REORD = 1'b1
    } map_mode_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    // Reverse the bit order of the label field.
    function automatic logic [LABEL_W-1:0] flip_label(input logic [LABEL_W-1:0] v);
        logic [LABEL_W-1:0] r;
        for (int i = 0; i < LABEL_W; i++) begin
            r[i] = v[LABEL_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_word_store.sv
module rx_word_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 push_data,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 head_data,
    output logic [$clog2(DEPTH+1)-1:0]       level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        // A write is judged against the current level only: no room, no store.
        do_push = push && (st_q.cnt != CNT_MAX);
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    assign head_data = mem_q[st_q.rd_ptr];
    assign level     = st_q.cnt;

    // R3: an offer to a full store with no pop leaves the level untouched.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == CNT_MAX) |=> (level == CNT_MAX));

    // R6: a pop on a non-empty store without a write lowers the level by one.
    p_pop_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level != '0) |=> (level == $past(level) - 1'b1));

    // R12: popping an empty store keeps it empty.
    p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> (level == '0));

    // R13: a write and a pop together on a partly filled store keep the level.
    p_swap_level_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && level != '0 && level != CNT_MAX) |=> $stable(level));

    // R9: the level never passes the depth.
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_MAX);

endmodule

// File: rtl/rx_half_mapper.sv
module rx_half_mapper
    import arx_rx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              word_ok,
    input  logic              enable,
    input  logic              half,
    input  logic              mode,
    output logic [HALF_W-1:0] bus
);

    logic [HALF_W-1:0] lo_raw, hi_raw, lo_reord, hi_reord;
    logic [HALF_W-1:0] pick;

    always_comb begin
        lo_raw   = word[15:0];
        hi_raw   = word[31:16];
        // Reordered: low data bits, SDI pair, then label with its bits flipped.
        lo_reord = {word[15:10], word[9:8], flip_label(word[7:0])};
        // Reordered: high data bits, SSM pair, parity in bit 0.
        hi_reord = {word[28:16], word[30:29], word[31]};
        unique case ({map_mode_e'(mode), half_sel_e'(half)})
            {MAP_RAW,   HALF_LO}: pick = lo_raw;
            {MAP_RAW,   HALF_HI}: pick = hi_raw;
            {MAP_REORD, HALF_LO}: pick = lo_reord;
            default:              pick = hi_reord;
        endcase
        bus = (enable && word_ok) ? pick : '0;
    end

endmodule

// File: rtl/rx_split_fifo.sv
module rx_split_fifo
    import arx_rx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [31:0]       wr_word,
    input  logic              rd_en,
    input  logic              rd_half,
    input  logic              unscramble,
    output logic [15:0]       rd_data,
    output logic              data_ready,
    output logic              half_full,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

    logic [WORD_W-1:0] head_word;
    logic [CNT_W-1:0]  level;
    logic              pop_req;

    // The word leaves only on the upper-half step.
    assign pop_req = rd_en && (rd_half == HALF_HI);

    rx_word_store #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_word),
        .pop       (pop_req),
        .head_data (head_word),
        .level     (level)
    );

    rx_half_mapper i_mapper (
        .word    (head_word),
        .word_ok (level != '0),
        .enable  (rd_en),
        .half    (rd_half),
        .mode    (unscramble),
        .bus     (rd_data)
    );

    assign data_ready = (level != '0);
    assign half_full  = (level >= CNT_HALF);
    assign full       = (level == CNT_MAX);

    // R4: the bus stays quiet with no read enable.
    p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

    // R9: full implies the half-level flag.
    p_full_implies_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full);

    // R7: any level flag implies words are available.
    p_half_implies_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> data_ready);

    // R5: a lower-half read leaves the availability flag as it was.
    p_lo_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_half && !wr_valid) |=> $stable(data_ready));

endmodule

// File: tb/test_rx_split_fifo.sv
module test_rx_split_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_word = '0;
    logic        rd_en = 1'b0;
    logic        rd_half = 1'b0;
    logic        unscramble = 1'b0;
    logic [15:0] rd_data;
    logic        data_ready, half_full, full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model[$];

    always #4 clk = ~clk;

    rx_split_fifo i_rx_split_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_word    (wr_word),
        .rd_en      (rd_en),
        .rd_half    (rd_half),
        .unscramble (unscramble),
        .rd_data    (rd_data),
        .data_ready (data_ready),
        .half_full  (half_full),
        .full       (full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_half(input logic [31:0] w, input bit mode, input bit h);
        logic [7:0] lab;
        for (int i = 0; i < 8; i++) lab[i] = w[7-i];
        if (!mode) return h ? w[31:16] : w[15:0];
        if (!h) return {w[15:10], w[9:8], lab};
        return {w[28:16], w[30:29], w[31]};
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_word  = w;
        if (model.size() < 32) model.push_back(w);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic read_half(input bit h, output logic [15:0] d);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_half = h;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        if (h && model.size() > 0) void'(model.pop_front());
    endtask

    task automatic check_flags(input string req, input int n);
        chk({req, " data_ready"}, 32'(data_ready), 32'(n > 0));
        chk({req, " half_full"}, 32'(half_full), 32'(n >= 16));
        chk({req, " full"}, 32'(full), 32'(n == 32));
    endtask

    task automatic read_and_check(input string req, input bit mode);
        logic [31:0] w;
        logic [15:0] lo, hi;
        w = model[0];
        unscramble = mode;
        read_half(1'b0, lo);
        read_half(1'b1, hi);
        chk({req, " lower half"}, 32'(lo), 32'(exp_half(w, mode, 1'b0)));
        chk({req, " upper half"}, 32'(hi), 32'(exp_half(w, mode, 1'b1)));
    endtask

    task automatic t_reset;
        #1;
        check_flags("R1", 0);
        chk("R1 rd_data", 32'(rd_data), 32'h0);
    endtask

    task automatic t_order_raw;
        push_word(32'hA1B2_C3D4);
        push_word(32'h1357_9BDF);
        push_word(32'h0F0F_F0F0);
        check_flags("R7", 3);
        read_and_check("R2 R10 first", 1'b0);
        read_and_check("R2 R10 second", 1'b0);
        read_and_check("R2 R10 third", 1'b0);
        check_flags("R6 R7 drained", 0);
    endtask

    task automatic t_lower_repeat;
        logic [15:0] a, b;
        push_word(32'hDEAD_BEEF);
        unscramble = 1'b0;
        read_half(1'b0, a);
        read_half(1'b0, b);
        chk("R5 first lower", 32'(a), 32'hBEEF);
        chk("R5 repeat lower", 32'(b), 32'hBEEF);
        check_flags("R5 no pop", 1);
        read_half(1'b1, a);
        chk("R5 upper", 32'(a), 32'hDEAD);
        check_flags("R6 popped", 0);
    endtask

    task automatic t_idle_bus;
        push_word(32'h5555_AAAA);
        #1 chk("R4 idle bus", 32'(rd_data), 32'h0);
        read_and_check("R4 after idle", 1'b0);
    endtask

    task automatic t_reorder;
        // label 0x01 -> 0x80; sdi=2; low data=0x2B; high data=0x1ABC; ssm=1; parity=1
        logic [31:0] w;
        w = {1'b1, 2'b01, 13'h1ABC, 6'h2B, 2'b10, 8'h01};
        push_word(w);
        read_and_check("R11 pattern", 1'b1);
        push_word(32'h8000_00F0);
        read_and_check("R11 label/parity", 1'b1);
    endtask

    task automatic t_fill;
        logic [15:0] d;
        for (int i = 0; i < 15; i++) push_word(32'h1000_0000 + i);
        check_flags("R8 at 15", 15);
        push_word(32'h1000_000F);
        check_flags("R8 at 16", 16);
        for (int i = 16; i < 31; i++) push_word(32'h1000_0000 + i);
        check_flags("R9 at 31", 31);
        push_word(32'h1000_001F);
        check_flags("R9 at 32", 32);
        push_word(32'hFFFF_FFFF);
        check_flags("R3 after drop", 32);
        for (int i = 0; i < 32; i++) begin
            unscramble = 1'b0;
            read_half(1'b0, d);
            chk("R3 R2 drain lower", 32'(d), 32'(16'(i)));
            read_half(1'b1, d);
            chk("R3 R2 drain upper", 32'(d), 32'h1000);
            if (i == 0) check_flags("R9 after one pop", 31);
            if (i == 16) check_flags("R8 at 15 draining", 15);
        end
        check_flags("R3 empty after 32", 0);
    endtask

    task automatic t_empty_read;
        logic [15:0] d;
        read_half(1'b1, d);
        chk("R12 empty bus", 32'(d), 32'h0);
        check_flags("R12 still empty", 0);
        push_word(32'h2468_ACE0);
        check_flags("R12 one after", 1);
        read_and_check("R12 clean pointer", 1'b0);
    endtask

    task automatic t_swap;
        logic [15:0] d;
        push_word(32'h1111_2222);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_word  = 32'h3333_4444;
        rd_en    = 1'b1;
        rd_half  = 1'b1;
        unscramble = 1'b0;
        #1 chk("R13 swap out", 32'(rd_data), 32'h1111);
        @(negedge clk);
        wr_valid = 1'b0;
        rd_en    = 1'b0;
        void'(model.pop_front());
        model.push_back(32'h3333_4444);
        check_flags("R13 level kept", 1);
        read_and_check("R13 new word", 1'b0);
        check_flags("R13 drained", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_order_raw();
        t_lower_repeat();
        t_idle_bus();
        t_reorder();
        t_fill();
        t_empty_read();
        t_swap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule